// File: doc/BRIEF.md
# Commutative Update Merge Engine

This block folds privatized cache lines back into shared memory when the updates made to them commute. When a core first touches a line commutatively, the cache hands the engine a copy of that line. The engine keeps the copy in a small source buffer, and the line in the local cache becomes the updated copy. Later the line is either merged on request or evicted. The engine then locks the line's last-level entry, reads the current memory contents and combines the source, updated and memory lines with a merge function. It writes the result back and releases the lock.

Each captured line carries a slot index into a small table of function codes, `fn_cfg`. The code in that slot picks the merge function: a per-lane add of the delta, an OR, an XOR of the delta, or a per-lane unsigned maximum.

A soft-merge pulse marks every line held at that moment as mergeable. When a mergeable line is evicted it is merged. Any other eviction is written back as a plain copy.

Three interfaces are valid/ready streams: capture (`cap_*`), merge/evict requests (`req_*`) and the memory write (`mwr_valid`/`mwr_ack`). A producer must hold valid and its payload steady until the cycle in which ready (or ack) is high, and a transfer happens on that edge. The lock (`lock_req`/`lock_gnt`) and the memory read (`mrd_req`/`mrd_rvalid`) are level handshakes. The flush request and the soft-merge pulse are plain pins.

Top module: `cme_engine`

## Requirements
- R1: After reset the buffer is empty. `req_ready` is 1 and `cap_ready` is 1 while `req_valid` is 0. `lock_req`, `mrd_req`, `mwr_valid` and `flush_req` are all 0.
- R2: A capture of an address not in the buffer stores the address, the 512-bit line and the 2-bit function slot. A capture of an address that is already held is accepted and leaves the first copy unchanged.
- R3: The buffer holds 4 lines. When it is full and a capture of a new address is pending, `cap_ready` is 0, `flush_req` is 1 and `flush_addr` is the address of the oldest held line. The capture is accepted once an entry frees.
- R4: An explicit merge (`req_evict`=0) of a held line removes its entry on acceptance. It then locks the line, reads memory once, writes the merge result once and returns `req_ready` high. Slot s of `fn_cfg` is bits [2s+1:2s]. The code in that slot selects the function: 0 add-delta, 1 OR, 2 XOR-delta, 3 max.
- R5: Code 0 gives, in each of eight 64-bit lanes, memory + (updated − source) modulo 2^64.
- R6: Code 1 gives memory OR updated.
- R7: Code 2 gives memory XOR updated XOR source.
- R8: Code 3 gives, in each 64-bit lane, the unsigned maximum of memory and updated.
- R9: A merge of a held line whose updated data equals its source frees the entry with no lock, no read and no write.
- R10: `soft_merge` marks every line held before that edge. A line captured on the same edge is not marked. Evicting (`req_evict`=1) a marked line merges it. Evicting an unmarked held line writes the updated data to memory unchanged and frees the entry.
- R11: An explicit merge of an address not held is accepted and ignored. An eviction of an address not held writes the updated data to memory.
- R12: `lock_req` rises before any read or write and stays high until `lock_gnt` is seen. It stays high through the cycle after `mwr_ack` and falls in the next cycle. `mrd_req` and `mwr_valid` are asserted only while the lock is granted.
- R13: When a capture and a request are both valid in an idle cycle, the request is taken and `cap_ready` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_cfg | input | 8 | Four 2-bit function codes, one per slot |
| soft_merge | input | 1 | Marks all held lines mergeable |
| cap_valid | input | 1 | Source capture valid |
| cap_ready | output | 1 | Source capture ready |
| cap_addr | input | 32 | Line address of the capture |
| cap_fid | input | 2 | Function slot for the line |
| cap_data | input | 512 | Source copy of the line |
| flush_req | output | 1 | Buffer full; the oldest line must be merged |
| flush_addr | output | 32 | Address of the oldest held line |
| req_valid | input | 1 | Merge/evict request valid |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_evict | input | 1 | 1 = eviction, 0 = explicit merge |
| req_addr | input | 32 | Line address of the request |
| req_data | input | 512 | Updated local copy of the line |
| lock_req | output | 1 | Last-level line lock request |
| lock_addr | output | 32 | Line being locked |
| lock_gnt | input | 1 | Lock granted |
| mrd_req | output | 1 | Memory read request, held until data returns |
| mrd_addr | output | 32 | Read address |
| mrd_rvalid | input | 1 | Read data valid |
| mrd_data | input | 512 | Current memory line |
| mwr_valid | output | 1 | Memory write valid |
| mwr_addr | output | 32 | Write address |
| mwr_data | output | 512 | Line to write |
| mwr_ack | input | 1 | Write accepted |

## Verification
Two things can coincide in one cycle. A capture and a merge request can both be valid while the engine is idle, and a soft-merge pulse can arrive on the same edge that accepts a capture. The bench raises both valids at the same falling edge and checks that only the request side shows ready. It then lets the capture complete. Separately, it pulses `soft_merge` together with a new capture and evicts both lines afterwards: the older line must come back merged, and the newly captured one as a plain copy of its updated data. A behavioural queue model predicts the flush request and flush address on every clock.

// File: rtl/cme_pkg.sv
package cme_pkg;
  parameter int ADDR_W  = 32;
  parameter int LINE_W  = 512;
  parameter int LANE_W  = 64;
  parameter int FID_W   = 2;
  parameter int FCODE_W = 2;
  localparam int NLANE  = LINE_W / LANE_W;
  localparam int NFN    = 1 << FID_W;

  typedef enum logic [FCODE_W-1:0] {
    FN_ADD = 2'd0,
    FN_OR  = 2'd1,
    FN_XOR = 2'd2,
    FN_MAX = 2'd3
  } fcode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK, ST_READ, ST_WRITE, ST_REL
  } st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LINE_W-1:0] data;
    logic [FID_W-1:0]  fid;
    logic              mark;
  } entry_t;
endpackage

// File: rtl/cme_merge_alu.sv
module cme_merge_alu
  import cme_pkg::*;
(
  input  fcode_e            fcode,
  input  logic [LINE_W-1:0] src,
  input  logic [LINE_W-1:0] upd,
  input  logic [LINE_W-1:0] mem,
  output logic [LINE_W-1:0] res
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] ls, lu, lm, lr;
    assign ls = src[g*LANE_W +: LANE_W];
    assign lu = upd[g*LANE_W +: LANE_W];
    assign lm = mem[g*LANE_W +: LANE_W];
    always_comb begin
      case (fcode)
        FN_ADD:  lr = lm + (lu - ls);
        FN_OR:   lr = lm | lu;
        FN_XOR:  lr = lm ^ lu ^ ls;
        default: lr = (lu > lm) ? lu : lm;
      endcase
    end
    assign res[g*LANE_W +: LANE_W] = lr;
  end
endmodule

// File: rtl/cme_srcbuf.sv
module cme_srcbuf
  import cme_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic              cap_hit,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_hit,
  output logic [IW-1:0]     req_idx,
  output entry_t            req_ent,
  input  logic              ins_en,
  input  entry_t            ins_ent,
  input  logic              rm_en,
  input  logic [IW-1:0]     rm_idx,
  input  logic              mark_all,
  output logic              full,
  output logic [ADDR_W-1:0] head_addr
);
  entry_t         ents   [DEPTH];
  entry_t         n_ents [DEPTH];
  logic [CW-1:0]  cnt, n_cnt;

  always_comb begin
    cap_hit = 1'b0;
    req_hit = 1'b0;
    req_idx = '0;
    req_ent = ents[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt && ents[i].addr == cap_addr) cap_hit = 1'b1;
      if (CW'(i) < cnt && ents[i].addr == req_addr) begin
        req_hit = 1'b1;
        req_idx = IW'(i);
        req_ent = ents[i];
      end
    end
  end

  always_comb begin
    n_cnt = cnt;
    for (int i = 0; i < DEPTH; i++) begin
      n_ents[i] = ents[i];
      if (mark_all && CW'(i) < cnt) n_ents[i].mark = 1'b1;
    end
    if (rm_en) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (IW'(i) >= rm_idx) n_ents[i] = n_ents[i+1];
      n_cnt = n_cnt - 1'b1;
    end
    if (ins_en) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == n_cnt) n_ents[i] = ins_ent;
      n_cnt = n_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= n_cnt;
    for (int i = 0; i < DEPTH; i++) ents[i] <= n_ents[i];
  end

  assign full      = (cnt == CW'(DEPTH));
  assign head_addr = ents[0].addr;
endmodule

// File: rtl/cme_engine.sv
module cme_engine
  import cme_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NFN*FCODE_W-1:0] fn_cfg,
  input  logic                   soft_merge,
  input  logic                   cap_valid,
  output logic                   cap_ready,
  input  logic [ADDR_W-1:0]      cap_addr,
  input  logic [FID_W-1:0]       cap_fid,
  input  logic [LINE_W-1:0]      cap_data,
  output logic                   flush_req,
  output logic [ADDR_W-1:0]      flush_addr,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_evict,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [LINE_W-1:0]      req_data,
  output logic                   lock_req,
  output logic [ADDR_W-1:0]      lock_addr,
  input  logic                   lock_gnt,
  output logic                   mrd_req,
  output logic [ADDR_W-1:0]      mrd_addr,
  input  logic                   mrd_rvalid,
  input  logic [LINE_W-1:0]      mrd_data,
  output logic                   mwr_valid,
  output logic [ADDR_W-1:0]      mwr_addr,
  output logic [LINE_W-1:0]      mwr_data,
  input  logic                   mwr_ack
);
  st_e               st;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] src_q, upd_q, wr_q;
  fcode_e            fcode_q;
  logic              rd_q;

  logic              cap_hit, req_hit, full, fire, take, same, go_merge, go_plain, ins_en;
  logic [IW-1:0]     req_idx;
  entry_t            req_ent, ins_ent;
  logic [LINE_W-1:0] alu_res;

  assign req_ready = (st == ST_IDLE);
  assign cap_ready = (st == ST_IDLE) && !req_valid && (cap_hit || !full);
  assign flush_req = cap_valid && full && !cap_hit;
  assign ins_en    = cap_valid && cap_ready && !cap_hit;
  assign ins_ent   = '{addr: cap_addr, data: cap_data, fid: cap_fid, mark: 1'b0};

  assign fire     = req_valid && req_ready;
  assign same     = (req_ent.data == req_data);
  assign take     = req_hit && (!req_evict || req_ent.mark);
  assign go_merge = take && !same;
  assign go_plain = req_evict && !take;

  cme_srcbuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .cap_addr(cap_addr), .cap_hit(cap_hit),
    .req_addr(req_addr), .req_hit(req_hit), .req_idx(req_idx), .req_ent(req_ent),
    .ins_en(ins_en), .ins_ent(ins_ent),
    .rm_en(fire && req_hit), .rm_idx(req_idx),
    .mark_all(soft_merge),
    .full(full), .head_addr(flush_addr)
  );

  cme_merge_alu u_alu (
    .fcode(fcode_q), .src(src_q), .upd(upd_q), .mem(mrd_data), .res(alu_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      rd_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (fire && (go_merge || go_plain)) begin
          st      <= ST_LOCK;
          addr_q  <= req_addr;
          src_q   <= req_ent.data;
          upd_q   <= req_data;
          fcode_q <= fcode_e'(fn_cfg[req_ent.fid*FCODE_W +: FCODE_W]);
          rd_q    <= go_merge;
        end
        ST_LOCK: if (lock_gnt) begin
          if (rd_q) st <= ST_READ;
          else begin
            wr_q <= upd_q;
            st   <= ST_WRITE;
          end
        end
        ST_READ: if (mrd_rvalid) begin
          wr_q <= alu_res;
          st   <= ST_WRITE;
        end
        ST_WRITE: if (mwr_ack) st <= ST_REL;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign lock_req  = (st != ST_IDLE);
  assign mrd_req   = (st == ST_READ);
  assign mwr_valid = (st == ST_WRITE);
  assign lock_addr = addr_q;
  assign mrd_addr  = addr_q;
  assign mwr_addr  = addr_q;
  assign mwr_data  = wr_q;
endmodule

// File: rtl/cme_engine_chk.sv
module cme_engine_chk
  import cme_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_ready,
  input logic              flush_req,
  input logic              req_valid,
  input logic              req_ready,
  input logic              lock_req,
  input logic              mrd_req,
  input logic              mrd_rvalid,
  input logic              mwr_valid,
  input logic              mwr_ack,
  input logic [ADDR_W-1:0] mwr_addr,
  input logic [LINE_W-1:0] mwr_data
);
  p_flush_blocks_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !cap_ready);

  p_mem_under_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req || mwr_valid) |-> lock_req);

  p_release_after_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && mwr_ack) |=> (lock_req ##1 !lock_req));

  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && !mwr_ack) |=> (mwr_valid && $stable(mwr_addr) && $stable(mwr_data)));

  p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req && !mrd_rvalid) |=> mrd_req);

  p_busy_blocks_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |-> !req_ready);

  p_req_over_cap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !cap_ready);
endmodule

bind cme_engine cme_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_ready(cap_ready), .flush_req(flush_req),
  .req_valid(req_valid), .req_ready(req_ready), .lock_req(lock_req),
  .mrd_req(mrd_req), .mrd_rvalid(mrd_rvalid), .mwr_valid(mwr_valid),
  .mwr_ack(mwr_ack), .mwr_addr(mwr_addr), .mwr_data(mwr_data)
);

// File: tb/sim_cme_engine.sv
`timescale 1ns/1ps
module sim_cme_engine;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [7:0]   fn_cfg = {2'd1, 2'd0, 2'd3, 2'd2}; // slot0=XOR slot1=MAX slot2=ADD slot3=OR
  logic         soft_merge = 0, cap_valid = 0, req_valid = 0, req_evict = 0;
  logic [31:0]  cap_addr = 0, req_addr = 0;
  logic [1:0]   cap_fid = 0;
  logic [511:0] cap_data = 0, req_data = 0, mrd_data = 0;
  logic         lock_gnt = 0, mrd_rvalid = 0, mwr_ack = 0;
  logic         cap_ready, flush_req, req_ready, lock_req, mrd_req, mwr_valid;
  logic [31:0]  flush_addr, lock_addr, mrd_addr, mwr_addr;
  logic [511:0] mwr_data;

  cme_engine u0 (.*);

  typedef struct { logic [31:0] a; logic [511:0] d; int f; bit mk; } ment_t;
  ment_t mq[$];
  logic [511:0] mem_m [logic [31:0]];
  int nchk = 0, nfail = 0, nwr = 0, nlock = 0, gdel = 0, gcnt = 0, rdc = 0;
  bit lock_prev = 0, done = 0;

  task automatic ck(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] pat(input logic [63:0] base, input logic [63:0] step);
    logic [511:0] r;
    for (int i = 0; i < 8; i++) r[i*64 +: 64] = base + step * 64'(i);
    return r;
  endfunction

  function automatic logic [511:0] memval(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : '0;
  endfunction

  function automatic int find(input logic [31:0] a);
    foreach (mq[i]) if (mq[i].a == a) return i;
    return -1;
  endfunction

  function automatic logic [511:0] ref_merge(input int f, input logic [511:0] s, u, m);
    logic [511:0] r;
    int code;
    code = int'(fn_cfg[f*2 +: 2]);
    for (int i = 0; i < 8; i++) begin
      logic [63:0] ls, lu, lm;
      ls = s[i*64 +: 64]; lu = u[i*64 +: 64]; lm = m[i*64 +: 64];
      case (code)
        0: r[i*64 +: 64] = lm + lu - ls;
        1: r[i*64 +: 64] = lm | lu;
        2: r[i*64 +: 64] = lm ^ lu ^ ls;
        default: r[i*64 +: 64] = (lu > lm) ? lu : lm;
      endcase
    end
    return r;
  endfunction

  // memory and lock responders
  initial forever begin
    @(negedge clk);
    gcnt = lock_req ? gcnt + 1 : 0;
    lock_gnt = lock_req && (gcnt > gdel);
    mrd_rvalid = 0;
    if (mrd_req) begin
      if (rdc == 1) begin
        mrd_rvalid = 1; mrd_data = memval(mrd_addr); rdc = 0;
      end else rdc++;
    end
    mwr_ack = 0;
    if (mwr_valid) begin
      mwr_ack = 1; mem_m[mwr_addr] = mwr_data; nwr++;
    end
  end

  // per-clock comparison against the queue model
  initial forever begin
    bit ef;
    @(posedge clk); #8;
    if (rst_n) begin
      ef = cap_valid && mq.size() == 4 && find(cap_addr) < 0;
      ck(flush_req === ef, "R3 flush_req", 512'(flush_req), 512'(ef));
      if (ef) ck(flush_addr === mq[0].a, "R3 flush_addr", 512'(flush_addr), 512'(mq[0].a));
      if (mrd_req || mwr_valid) ck(lock_gnt === 1'b1, "R12 access without grant", 512'(lock_gnt), 512'(1));
      if (lock_req && !lock_prev) nlock++;
      lock_prev = lock_req;
    end
  end

  task automatic do_cap(input logic [31:0] a, input logic [511:0] d, input int f, input bit sm);
    @(negedge clk);
    cap_valid = 1; cap_addr = a; cap_data = d; cap_fid = 2'(f); soft_merge = sm;
    #1;
    while (!cap_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (sm) foreach (mq[i]) mq[i].mk = 1;
    if (find(a) < 0) mq.push_back('{a, d, f, 1'b0});
    @(negedge clk);
    cap_valid = 0; soft_merge = 0;
  endtask

  task automatic do_req(input logic [31:0] a, input logic [511:0] u, input bit ev, input string tag);
    int w0, l0, idx;
    bit expw;
    logic [511:0] m0, expm;
    w0 = nwr; l0 = nlock;
    @(negedge clk);
    req_valid = 1; req_evict = ev; req_addr = a; req_data = u;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    idx = find(a); m0 = memval(a); expw = 0; expm = m0;
    if (idx >= 0) begin
      ment_t e = mq[idx];
      mq.delete(idx);
      if (!ev || e.mk) begin
        if (e.d !== u) begin expw = 1; expm = ref_merge(e.f, e.d, u, m0); end
      end else begin expw = 1; expm = u; end
    end else if (ev) begin expw = 1; expm = u; end
    @(negedge clk);
    req_valid = 0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    ck(nwr - w0 == int'(expw), {tag, " write count"}, 512'(nwr - w0), 512'(expw));
    ck(nlock - l0 == int'(expw), {tag, " R12 lock count"}, 512'(nlock - l0), 512'(expw));
    ck(memval(a) === expm, {tag, " memory line"}, memval(a), expm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    ck(req_ready === 1 && cap_ready === 1, "R1 ready after reset", {req_ready, cap_ready}, 2'b11);
    ck({lock_req, mrd_req, mwr_valid, flush_req} === 4'b0, "R1 idle outputs", {lock_req, mrd_req, mwr_valid, flush_req}, 0);

    // function codes through the slot table, with lane wraparound on add
    mem_m[32'h100] = pat(64'hFFFF_FFFF_FFFF_FFF0, 1);
    do_cap(32'h100, pat(100, 3), 2, 0);
    do_req(32'h100, pat(5, 7), 0, "R5 add-delta wrap R4");
    mem_m[32'h140] = pat(64'h0F0F, 64'h100);
    do_cap(32'h140, pat(1, 1), 3, 0);
    do_req(32'h140, pat(64'hA000, 64'h11), 0, "R6 or");
    mem_m[32'h180] = pat(64'h5555_0000, 64'h33);
    do_cap(32'h180, pat(64'h1234, 64'h9), 0, 0);
    do_req(32'h180, pat(64'h4321, 64'h5), 0, "R7 xor-delta");
    mem_m[32'h1C0] = pat(64'h800, 64'hFFFF_FFFF_FFFF_FF00);
    gdel = 3;
    do_cap(32'h1C0, pat(0, 0), 1, 0);
    do_req(32'h1C0, pat(64'h400, 64'h100), 0, "R8 max R12 slow grant");
    gdel = 0;

    // skip, absent lines, duplicate capture
    do_cap(32'h200, pat(9, 9), 2, 0);
    do_req(32'h200, pat(9, 9), 0, "R9 equal skip");
    do_req(32'h240, pat(3, 3), 0, "R11 absent merge ignored");
    do_req(32'h280, pat(64'hBEEF, 2), 1, "R11 absent evict plain");
    do_cap(32'h2C0, pat(50, 1), 2, 0);
    do_cap(32'h2C0, pat(77, 1), 2, 0);
    do_req(32'h2C0, pat(50, 1), 0, "R2 duplicate keeps first");

    // soft-merge in the same cycle as a capture
    mem_m[32'h300] = pat(1000, 10);
    mem_m[32'h340] = pat(2000, 10);
    do_cap(32'h300, pat(10, 1), 2, 0);
    do_cap(32'h340, pat(20, 1), 2, 1);
    do_req(32'h300, pat(15, 2), 1, "R10 marked evict merges");
    do_req(32'h340, pat(25, 2), 1, "R10 same-cycle capture unmarked");

    // capture and request valid in the same idle cycle
    @(negedge clk);
    cap_valid = 1; cap_addr = 32'h380; cap_data = pat(7, 7); cap_fid = 0;
    req_valid = 1; req_evict = 0; req_addr = 32'h3C0; req_data = pat(1, 1);
    #1;
    ck(cap_ready === 0 && req_ready === 1, "R13 request wins", {cap_ready, req_ready}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    #1;
    ck(cap_ready === 1, "R13 capture follows", 512'(cap_ready), 1);
    @(posedge clk);
    mq.push_back('{32'h380, pat(7, 7), 0, 1'b0});
    @(negedge clk);
    cap_valid = 0;
    do_req(32'h380, pat(7, 7), 0, "R13 cleanup R9");

    // overflow: oldest entry must be flushed
    for (int i = 0; i < 4; i++) do_cap(32'h400 + 32'(i * 64), pat(64'(i), 1), 2, 0);
    @(negedge clk);
    cap_valid = 1; cap_addr = 32'h500; cap_data = pat(8, 8); cap_fid = 3;
    repeat (3) @(negedge clk);
    #1;
    ck(cap_ready === 0 && flush_req === 1, "R3 full blocks capture", {cap_ready, flush_req}, 2'b01);
    ck(flush_addr === 32'h400, "R3 oldest address", 512'(flush_addr), 512'(32'h400));
    @(negedge clk);
    cap_valid = 0;
    do_req(32'h400, pat(64'h99, 1), 0, "R3 flush merge R4");
    do_cap(32'h500, pat(8, 8), 3, 0);
    ck(mq.size() == 4, "R3 capture accepted after flush", 512'(mq.size()), 4);
    do_req(32'h440, pat(64'h1, 1), 0, "R4 second oldest merge");

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule